// File: doc/BRIEF.md
# Chainable PWM Time-Base Counter

This block is the timing heart of one PWM channel. A two-stage divider turns the system clock into a counting tick. On every tick a 16-bit counter steps against an active period value. It can count up, count down, count up and then down, or hold still. The block reports when the count is zero, when it equals the period, and which way it is moving. Compare and output-action logic sit outside the block and use these signals.

Several channels can be linked in a chain. Any of four sync sources can load a programmed phase value into the counter: the upstream sync input, a software force strobe, or one of two digital-compare events. This keeps a channel aligned with the channel before it. A selectable sync output then feeds the next channel. The period value has a shadow copy and an active copy, so a new period can take effect at once or wait for the next zero of the count.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, `dir_o` is 1 (counting up), and the active and shadow period values are 0.
- R2: A tick occurs once every HS*CD system clocks. HS is 1 for `hs_div_i` = 0 and 2*`hs_div_i` otherwise. CD is 2^`clk_div_i`. The counter changes state only on a tick.
- R3: With mode code 0 (up), each tick adds one. A count at or above the active period goes to 0 instead. `dir_o` is 1.
- R4: With mode code 1 (down), each tick subtracts one. A count of 0, or a count above the active period, reloads the active period. `dir_o` is 0.
- R5: With mode code 2 (up-down), the counter rises to the active period and then falls to 0, and repeats. `dir_o` is 1 while rising and 0 while falling. The direction register changes on the tick that leaves the turning point. If the period is 0, the count stays at 0.
- R6: With mode code 3 (hold), the counter and direction do not change. No zero, period or CMPB-match events are produced.
- R7: `zero_o` is high for one clock on a tick when the count is 0. `prd_o` is high for one clock on a tick when the count equals the active period.
- R8: A period write with `prd_direct_i`=1 updates the active and shadow copies on the next edge. With `prd_direct_i`=0 a write updates only the shadow copy. The shadow copy then moves to the active copy on the clock of the next zero event.
- R9: When `phs_en_i` is 1, a pulse on `sync_i`, `sw_force_i`, `dca_sync_i` or `dcb_sync_i` loads `phs_i` into the counter on the next edge. This takes priority over the tick and leaves the direction unchanged.
- R10: When `phs_en_i` is 0, these sync pulses do not change the counter.
- R11: `sync_o` is selected by `sync_sel_i`. Code 0 passes `sync_i` through. Code 1 gives the zero event. Code 2 gives a tick with the count equal to `cmpb_i` (not in hold mode). Code 3 keeps the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_div_i | input | 3 | High-speed divider code |
| clk_div_i | input | 3 | Second divider code (power of two) |
| cnt_mode_i | input | 2 | 0 up, 1 down, 2 up-down, 3 hold |
| prd_wr_i | input | 1 | Period write strobe |
| prd_wdata_i | input | 16 | Period write value |
| prd_direct_i | input | 1 | 1: write to active copy; 0: through shadow |
| phs_i | input | 16 | Phase value loaded on sync |
| phs_en_i | input | 1 | Enables phase load on sync |
| sync_i | input | 1 | Upstream sync pulse |
| sw_force_i | input | 1 | Software sync strobe, one cycle |
| dca_sync_i | input | 1 | Digital-compare A1 sync event |
| dcb_sync_i | input | 1 | Digital-compare B1 sync event |
| cmpb_i | input | 16 | Compare-B value for sync output |
| sync_sel_i | input | 2 | Sync output source select |
| cnt_o | output | 16 | Current count |
| dir_o | output | 1 | 1 counting up, 0 counting down |
| zero_o | output | 1 | Count-equals-zero event |
| prd_o | output | 1 | Count-equals-period event |
| sync_o | output | 1 | Sync pulse to the next channel |

## Verification
The assertions check several rules on every cycle. Hold mode and ignored sync pulses leave the count unchanged. An enabled sync loads the phase value on the next edge. Up mode keeps the count within the old period. The active period changes only after a direct write or a zero event. Two ticks never come back to back unless both dividers are set to one.

Other behaviour needs the bench scenarios, which compare every cycle against a reference model. These cover the full count sequences and turning points of each mode, delayed shadow transfer, each sync source, and each sync output selection. The bench also measures the spacing of zero events under several divider settings to show the tick rate.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'd0,
    SO_ZERO = 2'd1,
    SO_CMPB = 2'd2,
    SO_OFF  = 2'd3
  } sync_sel_e;
endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] hs_sel_i,
  input  logic [SEL_W-1:0] cd_sel_i,
  output logic             tick_o
);
  localparam int HS_W = SEL_W + 1;
  localparam int CD_W = 2**SEL_W - 1;

  logic [HS_W-1:0] hs_lim, hs_cnt;
  logic [CD_W-1:0] cd_lim, cd_cnt;
  logic [CD_W:0]   cd_pow;
  logic            hs_tick;

  always_comb begin
    hs_lim  = (hs_sel_i == '0) ? '0 : ({hs_sel_i, 1'b0} - HS_W'(1));
    cd_pow  = (CD_W+1)'(1) << cd_sel_i;
    cd_lim  = CD_W'(cd_pow - (CD_W+1)'(1));
    hs_tick = hs_cnt >= hs_lim;
    tick_o  = hs_tick && (cd_cnt >= cd_lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_cnt <= '0;
      cd_cnt <= '0;
    end else begin
      hs_cnt <= hs_tick ? '0 : hs_cnt + HS_W'(1);
      if (hs_tick) cd_cnt <= tick_o ? '0 : cd_cnt + CD_W'(1);
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o || (hs_lim == '0 && cd_lim == '0));
endmodule

// File: rtl/ptb_sync.sv
module ptb_sync
  import ptb_pkg::*;
(
  input  logic      sync_i,
  input  logic      sw_force_i,
  input  logic      dca_i,
  input  logic      dcb_i,
  input  sync_sel_e sel_i,
  input  logic      zero_i,
  input  logic      cmpb_hit_i,
  output logic      sync_ev_o,
  output logic      sync_o
);
  always_comb begin
    sync_ev_o = sync_i | sw_force_i | dca_i | dcb_i;
    unique case (sel_i)
      SO_PASS: sync_o = sync_i;
      SO_ZERO: sync_o = zero_i;
      SO_CMPB: sync_o = cmpb_hit_i;
      default: sync_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  cnt_mode_e     mode_i,
  input  logic          prd_wr_i,
  input  logic [CW-1:0] prd_wdata_i,
  input  logic          prd_direct_i,
  input  logic          sync_ev_i,
  input  logic          phs_en_i,
  input  logic [CW-1:0] phs_i,
  input  logic [CW-1:0] cmpb_i,
  output logic [CW-1:0] cnt_o,
  output logic          dir_o,
  output logic          zero_o,
  output logic          prd_o,
  output logic          cmpb_hit_o
);
  logic [CW-1:0] cnt_q, prd_act, prd_shd;
  logic          dir_q, run, step, load;

  always_comb begin
    run        = mode_i != MODE_HOLD;
    step       = tick_i && run;
    load       = sync_ev_i && phs_en_i;
    zero_o     = step && (cnt_q == '0);
    prd_o      = step && (cnt_q == prd_act);
    cmpb_hit_o = step && (cnt_q == cmpb_i);
    cnt_o      = cnt_q;
    dir_o      = dir_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_act <= '0;
      prd_shd <= '0;
    end else begin
      if (prd_wr_i) prd_shd <= prd_wdata_i;
      if (prd_wr_i && prd_direct_i) prd_act <= prd_wdata_i;
      else if (zero_o)              prd_act <= prd_shd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (load) begin
      cnt_q <= phs_i;
    end else if (step) begin
      unique case (mode_i)
        MODE_UP: begin
          dir_q <= 1'b1;
          cnt_q <= (cnt_q >= prd_act) ? '0 : cnt_q + CW'(1);
        end
        MODE_DOWN: begin
          dir_q <= 1'b0;
          cnt_q <= (cnt_q == '0 || cnt_q > prd_act) ? prd_act : cnt_q - CW'(1);
        end
        default: begin
          if (prd_act == '0) begin
            cnt_q <= '0;
          end else if (dir_q) begin
            if (cnt_q >= prd_act) begin
              dir_q <= 1'b0;
              cnt_q <= cnt_q - CW'(1);
            end else cnt_q <= cnt_q + CW'(1);
          end else begin
            if (cnt_q == '0) begin
              dir_q <= 1'b1;
              cnt_q <= CW'(1);
            end else cnt_q <= cnt_q - CW'(1);
          end
        end
      endcase
    end
  end

  // R6
  hold_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD && !load) |=> $stable(cnt_q) && $stable(dir_q));
  // R9
  phase_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_ev_i && phs_en_i) |=> cnt_q == $past(phs_i));
  // R10
  sync_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_ev_i && !phs_en_i && !tick_i) |=> $stable(cnt_q));
  // R8
  prd_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prd_act) |-> ($past(prd_wr_i && prd_direct_i) || $past(zero_o)));
  // R3
  up_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load && mode_i == MODE_UP && cnt_q <= prd_act) |=> cnt_q <= $past(prd_act));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int CW    = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] hs_div_i,
  input  logic [SEL_W-1:0] clk_div_i,
  input  logic [1:0]       cnt_mode_i,
  input  logic             prd_wr_i,
  input  logic [CW-1:0]    prd_wdata_i,
  input  logic             prd_direct_i,
  input  logic [CW-1:0]    phs_i,
  input  logic             phs_en_i,
  input  logic             sync_i,
  input  logic             sw_force_i,
  input  logic             dca_sync_i,
  input  logic             dcb_sync_i,
  input  logic [CW-1:0]    cmpb_i,
  input  logic [1:0]       sync_sel_i,
  output logic [CW-1:0]    cnt_o,
  output logic             dir_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic             sync_o
);
  logic tick, sync_ev, cmpb_hit;

  ptb_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i, .rst_ni, .hs_sel_i(hs_div_i), .cd_sel_i(clk_div_i), .tick_o(tick)
  );

  ptb_sync u_sync (
    .sync_i, .sw_force_i, .dca_i(dca_sync_i), .dcb_i(dcb_sync_i),
    .sel_i(sync_sel_e'(sync_sel_i)), .zero_i(zero_o), .cmpb_hit_i(cmpb_hit),
    .sync_ev_o(sync_ev), .sync_o
  );

  ptb_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .mode_i(cnt_mode_e'(cnt_mode_i)),
    .prd_wr_i, .prd_wdata_i, .prd_direct_i, .sync_ev_i(sync_ev), .phs_en_i,
    .phs_i, .cmpb_i, .cnt_o, .dir_o, .zero_o, .prd_o, .cmpb_hit_o(cmpb_hit)
  );

  // R11
  sync_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_sel_i == 2'd3) |-> !sync_o);
endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]  hs_div_i = '0, clk_div_i = '0;
  logic [1:0]  cnt_mode_i = 2'd0, sync_sel_i = 2'd3;
  logic        prd_wr_i = 0, prd_direct_i = 1, phs_en_i = 0;
  logic [15:0] prd_wdata_i = '0, phs_i = '0, cmpb_i = '0;
  logic        sync_i = 0, sw_force_i = 0, dca_sync_i = 0, dcb_sync_i = 0;
  logic [15:0] cnt_o;
  logic        dir_o, zero_o, prd_o, sync_o;

  always #2 clk_i = ~clk_i;

  pwm_timebase u_pwm_timebase (.*);

  typedef struct packed {
    logic [15:0] cnt; logic dir; logic zero; logic prd; logic so;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0, n_fail = 0;

  // bench reference state (tick every clock)
  logic [15:0] m_cnt = '0, m_act = '0, m_shd = '0;
  logic        m_dir = 1'b1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // driver: push expected outputs of this cycle, then advance the model
  task automatic cyc(string tag);
    exp_t e;
    logic run, zr, ev;
    run = cnt_mode_i != 2'd3;
    zr  = run && m_cnt == 16'd0;
    e.cnt = m_cnt; e.dir = m_dir; e.zero = zr;
    e.prd = run && m_cnt == m_act;
    case (sync_sel_i)
      2'd0: e.so = sync_i;
      2'd1: e.so = zr;
      2'd2: e.so = run && m_cnt == cmpb_i;
      default: e.so = 1'b0;
    endcase
    exp_q.push_back(e); tag_q.push_back(tag);
    ev = sync_i | sw_force_i | dca_sync_i | dcb_sync_i;
    if (ev && phs_en_i) m_cnt = phs_i;
    else if (run) begin
      case (cnt_mode_i)
        2'd0: begin m_dir = 1; m_cnt = (m_cnt >= m_act) ? 16'd0 : m_cnt + 1; end
        2'd1: begin m_dir = 0; m_cnt = (m_cnt == 0 || m_cnt > m_act) ? m_act : m_cnt - 1; end
        default: begin
          if (m_act == 0) m_cnt = 0;
          else if (m_dir) begin
            if (m_cnt >= m_act) begin m_dir = 0; m_cnt = m_cnt - 1; end
            else m_cnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin m_dir = 1; m_cnt = 1; end
            else m_cnt = m_cnt - 1;
          end
        end
      endcase
    end
    if (prd_wr_i && prd_direct_i) m_act = prd_wdata_i;
    else if (zr) m_act = m_shd;
    if (prd_wr_i) m_shd = prd_wdata_i;
    @(negedge clk_i);
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i); #1;
    if (exp_q.size() > 0) begin
      exp_t e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check({t, " cnt"},  {16'd0, cnt_o}, {16'd0, e.cnt});
      check({t, " dir"},  {31'd0, dir_o}, {31'd0, e.dir});
      check({t, " zero"}, {31'd0, zero_o}, {31'd0, e.zero});
      check({t, " prd"},  {31'd0, prd_o}, {31'd0, e.prd});
      check({t, " sync"}, {31'd0, sync_o}, {31'd0, e.so});
    end
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  // clocks between consecutive zero events
  task automatic gap(string tag, int exp);
    int n;
    do begin @(negedge clk_i); #1; end while (!zero_o);
    n = 0;
    do begin @(negedge clk_i); #1; n++; end while (!zero_o);
    check(tag, n, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    #1;
    check("R1 cnt", {16'd0, cnt_o}, 0);
    check("R1 dir", {31'd0, dir_o}, 1);
    @(negedge clk_i);
    rst_ni = 1;
    // R8 direct write, then R3/R7 up counting
    cnt_mode_i = 2'd0; prd_wr_i = 1; prd_wdata_i = 16'd4; prd_direct_i = 1;
    cyc("R8 direct");
    prd_wr_i = 0;
    repeat (12) cyc("R3/R7 up");
    cnt_mode_i = 2'd1;
    repeat (12) cyc("R4/R7 down");
    cnt_mode_i = 2'd2;
    repeat (14) cyc("R5 updown");
    cnt_mode_i = 2'd3;
    repeat (4) cyc("R6 hold");
    // R8 shadow path
    cnt_mode_i = 2'd0; prd_direct_i = 0; prd_wr_i = 1; prd_wdata_i = 16'd2;
    cyc("R8 shadow");
    prd_wr_i = 0;
    repeat (12) cyc("R8 shadow");
    prd_direct_i = 1;
    // R9 each sync source
    phs_en_i = 1; phs_i = 16'd1;
    sync_i = 1;     cyc("R9 sync_in");  sync_i = 0;     repeat (2) cyc("R9");
    sw_force_i = 1; cyc("R9 force");    sw_force_i = 0; repeat (2) cyc("R9");
    dca_sync_i = 1; cyc("R9 dca");      dca_sync_i = 0; repeat (2) cyc("R9");
    dcb_sync_i = 1; cyc("R9 dcb");      dcb_sync_i = 0; repeat (2) cyc("R9");
    cnt_mode_i = 2'd2; phs_i = 16'd2;
    sync_i = 1; cyc("R9 updown"); sync_i = 0; repeat (4) cyc("R9");
    // R10 sync ignored
    cnt_mode_i = 2'd3; phs_en_i = 0; phs_i = 16'd0;
    sync_i = 1; dca_sync_i = 1; cyc("R10"); sync_i = 0; dca_sync_i = 0;
    repeat (2) cyc("R10");
    cnt_mode_i = 2'd0;
    sw_force_i = 1; cyc("R10"); sw_force_i = 0; repeat (3) cyc("R10");
    // R11 sync output selects
    cmpb_i = 16'd1;
    for (int s = 0; s < 4; s++) begin
      sync_sel_i = 2'(s);
      sync_i = 1; cyc("R11"); sync_i = 0;
      repeat (7) cyc("R11");
    end
    while (exp_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    // R2 prescaler: up mode with period 3 gives a zero every 4 ticks
    prd_wr_i = 1; prd_wdata_i = 16'd3; @(negedge clk_i); prd_wr_i = 0;
    hs_div_i = 3'd1; clk_div_i = 3'd1; gap("R2 hs2 cd2", 16);
    hs_div_i = 3'd3; clk_div_i = 3'd2; gap("R2 hs6 cd4", 96);
    hs_div_i = 3'd7; clk_div_i = 3'd0; gap("R2 hs14 cd1", 56);
    hs_div_i = 3'd0; clk_div_i = 3'd3; gap("R2 hs1 cd8", 32);
    summary();
  end
endmodule